// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block derives the nominal bit timing of a CAN node from the system clock. A prescaler divides the clock into time quanta. Each bit is a chain of quanta. It begins with a one-quantum synchronization segment. A first timing segment follows, made of propagation compensation plus phase 1. A second timing segment, phase 2, ends the bit. The block pulses a strobe at the sample point and another at the bit boundary. It latches the receive line at the sample point.

The receive input passes through one register before it is used. A recessive-to-dominant transition on it (1 to 0) is a synchronization edge. With hard synchronization enabled, such an edge restarts the bit. Otherwise the edge causes at most one bounded correction per bit. A late edge stretches phase 1 and an early edge trims phase 2. The correction is never more than the jump width. A configuration flag warns when the segment settings break the ordering rule.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(brp+1) clocks. `tq_tick` is high for the last clock of every quantum, so it is never high two cycles in a row.
- R2: Without edges, a bit lasts 3+tseg1+tseg2 quanta. `bit_strobe` pulses on the `tq_tick` of the bit's last quantum. With brp=0, tseg1=4 and tseg2=3 this gives 20 clocks per bit.
- R3: `sample_strobe` pulses on the `tq_tick` that ends timing segment 1, which is tseg2+1 quanta before `bit_strobe`. On that strobe, `sampled_bit` takes the registered receive value and holds it until the next sample strobe.
- R4: `cfg_err` is 1 when tseg1 <= tseg2 or when tseg2 = 0, and 0 otherwise.
- R5: A synchronization edge that falls in quantum k of timing segment 1 (k = 1 for its first quantum) is a late edge. It lengthens that bit by min(k, sjw+1) quanta.
- R6: A synchronization edge in timing segment 2 is an early edge. Let e be the number of quanta left in the bit after the edge's quantum. The edge shortens that bit by min(e, sjw+1) quanta.
- R7: Only 1-to-0 transitions of the registered receive line act as edges. An edge inside the synchronization segment is ignored. After one correction, further edges in the same bit are ignored.
- R8: When `hsync_en` is 1, an edge restarts timing. The next clock is the first clock of a new synchronization segment, and no further correction is made in that bit.
- R9: During reset all strobes are 0 and `sampled_bit` is 1. Timing starts at the synchronization segment once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brp | input | 6 | Prescaler setting; quantum = 2*(brp+1) clocks |
| tseg1 | input | 4 | Timing segment 1 length minus one, in quanta |
| tseg2 | input | 3 | Timing segment 2 length minus one, in quanta |
| sjw | input | 2 | Jump width minus one, in quanta |
| hsync_en | input | 1 | 1: edges restart the bit; 0: edges resynchronize |
| rx | input | 1 | Receive bit (1 recessive, 0 dominant) |
| tq_tick | output | 1 | Last clock of each quantum |
| sample_strobe | output | 1 | Sample point pulse |
| bit_strobe | output | 1 | Bit boundary pulse |
| sampled_bit | output | 1 | Receive value latched at the sample point |
| cfg_err | output | 1 | Segment configuration is invalid |

## Verification
The bench places edges at known quanta. It puts edges deep in phase 1 and phase 2, where the jump width must clip the correction. A design that applied the raw phase error would give bit periods that are too long or too short. The bench also places an edge in the last quantum of phase 2, where the correction must be zero. It sends a second edge in an already corrected bit and an edge inside the synchronization segment; a design that did not ignore these would change the period a second time. A hard synchronization must restart the bit two clocks after the line falls. A design with an off-by-one in the quantum count would show a period error on every bit and a sample point that has slipped.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic [T1_W-1:0]  tseg1,
  input  logic [T2_W-1:0]  tseg2,
  input  logic [SJW_W-1:0] sjw,
  input  logic             hsync_en,
  input  logic             rx,
  output logic             tq_tick,
  output logic             sample_strobe,
  output logic             bit_strobe,
  output logic             sampled_bit,
  output logic             cfg_err
);
  localparam int PC_W  = BRP_W + 1;
  localparam int CNT_W = ((T1_W > SJW_W) ? T1_W : SJW_W) + 1;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} seg_t;

  seg_t             seg;
  logic [PC_W-1:0]  pc;
  logic [CNT_W-1:0] cnt, lim, lim_eff, perr, jump, jmax;
  logic             used, rx_s, rx_p;

  wire edge_f  = rx_p & ~rx_s;
  wire hs      = edge_f & hsync_en;
  wire rs      = edge_f & ~hsync_en & ~used & (seg != SEG_SYNC);

  assign jmax    = CNT_W'(sjw) + CNT_W'(1);
  assign tq_tick = (pc == {brp, 1'b1});
  assign cfg_err = (tseg1 <= T1_W'(tseg2)) | (tseg2 == '0);

  always_comb begin
    perr    = (seg == SEG_PH1) ? cnt + CNT_W'(1) : lim - cnt;
    jump    = rs ? ((perr < jmax) ? perr : jmax) : '0;
    lim_eff = (seg == SEG_PH1) ? lim + jump : lim - jump;
  end

  wire at_end = tq_tick & ~hs & (cnt == lim_eff);
  assign sample_strobe = at_end & (seg == SEG_PH1);
  assign bit_strobe    = at_end & (seg == SEG_PH2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s        <= 1'b1;
      rx_p        <= 1'b1;
      sampled_bit <= 1'b1;
    end else begin
      rx_s <= rx;
      rx_p <= rx_s;
      if (sample_strobe) sampled_bit <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      seg  <= SEG_SYNC;
      cnt  <= '0;
      lim  <= '0;
      used <= 1'b0;
    end else if (hs) begin
      pc   <= '0;
      seg  <= SEG_SYNC;
      cnt  <= '0;
      lim  <= '0;
      used <= 1'b1;
    end else begin
      lim <= lim_eff;
      if (rs) used <= 1'b1;
      if (tq_tick) begin
        pc <= '0;
        if (cnt == lim_eff) begin
          cnt <= '0;
          case (seg)
            SEG_SYNC: begin seg <= SEG_PH1;  lim <= CNT_W'(tseg1); end
            SEG_PH1:  begin seg <= SEG_PH2;  lim <= CNT_W'(tseg2); end
            default:  begin seg <= SEG_SYNC; lim <= '0; used <= 1'b0; end
          endcase
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        pc <= pc + PC_W'(1);
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tq_tick,
  input logic sample_strobe,
  input logic bit_strobe,
  input logic sampled_bit
);
  AST_TICK_GAP:      assert property (@(posedge clk) disable iff (!rst_n) tq_tick |=> !tq_tick); // R1
  AST_BIT_ON_TICK:   assert property (@(posedge clk) disable iff (!rst_n) bit_strobe |-> tq_tick); // R2
  AST_SAMP_ON_TICK:  assert property (@(posedge clk) disable iff (!rst_n) sample_strobe |-> tq_tick); // R3
  AST_STROBE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(sample_strobe && bit_strobe)); // R3
  AST_SAMPLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !sample_strobe |=> $stable(sampled_bit)); // R3
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .sample_strobe(sample_strobe),
  .bit_strobe(bit_strobe), .sampled_bit(sampled_bit)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic clk = 0, rst_n = 0, hsync_en = 0, rx = 1;
  logic [5:0] brp = 0;
  logic [3:0] tseg1 = 4;
  logic [2:0] tseg2 = 3;
  logic [1:0] sjw = 0;
  logic tq_tick, sample_strobe, bit_strobe, sampled_bit, cfg_err;

  can_bit_timer uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_bs = 0, last_ss = 0, period = 0, gap = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: position of the current quantum inside the bit
  int mpc, mq, t1end, bend, mused, mrs, mrp, msb;
  always @(negedge clk) begin
    int q, t1, t2, j, s, t1e, be;
    bit edg, hs, rsy, tick, es, eb, ecfg;
    cyc++;
    q = 2 * (brp + 1); t1 = tseg1 + 1; t2 = tseg2 + 1; j = sjw + 1;
    if (!rst_n) begin
      mpc = 0; mq = 0; t1end = t1; bend = t1 + t2; mused = 0; mrs = 1; mrp = 1; msb = 1;
    end
    edg = rst_n && mrp == 1 && mrs == 0;
    hs  = edg && hsync_en;
    rsy = edg && !hsync_en && mused == 0 && mq != 0;
    t1e = t1end; be = bend;
    if (rsy) begin
      if (mq <= t1end) begin s = (mq < j) ? mq : j; t1e += s; be += s; end
      else begin s = (bend - mq < j) ? bend - mq : j; be -= s; end
    end
    tick = rst_n && mpc == q - 1;
    es   = tick && !hs && mq != 0 && mq == t1e;
    eb   = tick && !hs && mq == be;
    ecfg = (tseg1 <= tseg2) || (tseg2 == 0);
    chk(tq_tick == tick, "R1 tq_tick", tq_tick, tick);
    chk(sample_strobe == es, "R3 sample_strobe", sample_strobe, es);
    chk(bit_strobe == eb, "R2 bit_strobe", bit_strobe, eb);
    chk(sampled_bit == msb[0], "R3 sampled_bit", sampled_bit, msb);
    chk(cfg_err == ecfg, "R4 cfg_err", cfg_err, ecfg);
    if (bit_strobe && rst_n) begin period = cyc - last_bs; gap = cyc - last_ss; last_bs = cyc; end
    if (sample_strobe && rst_n) last_ss = cyc;
    if (rst_n) begin
      if (hs) begin
        mpc = 0; mq = 0; t1end = t1; bend = t1 + t2; mused = 1;
      end else begin
        t1end = t1e; bend = be;
        if (rsy) mused = 1;
        if (tick) begin
          mpc = 0;
          if (es) msb = mrs;
          if (mq == be) begin mq = 0; mused = 0; t1end = t1; bend = t1 + t2; end
          else mq++;
        end else mpc++;
      end
      mrp = mrs; mrs = rx;
    end
  end

  task automatic setup(int b, int a1, int a2, int j);
    @(posedge clk); #1;
    rst_n = 0; brp = 6'(b); tseg1 = 4'(a1); tseg2 = 3'(a2); sjw = 2'(j); rx = 1; hsync_en = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!tq_tick && !sample_strobe && !bit_strobe, "R9 strobes in reset", {tq_tick, sample_strobe, bit_strobe}, 0);
    chk(sampled_bit == 1, "R9 sampled_bit in reset", sampled_bit, 1);
    rst_n = 1;
  endtask

  task automatic wait_bs;
    do @(negedge clk); while (!bit_strobe);
    @(posedge clk);
  endtask

  task automatic measure(output int p);
    do @(negedge clk); while (!bit_strobe);
    #1 p = period;
  endtask

  task automatic pulse(int d);
    repeat (d) @(posedge clk);
    #1 rx = 0;
    repeat (2) @(posedge clk);
    #1 rx = 1;
  endtask

  task automatic edge_test(int k, int q, int exp, string tag);
    int p;
    wait_bs;
    pulse(k * q);
    measure(p);
    chk(p == exp, tag, p, exp);
  endtask

  initial begin
    int p;
    setup(0, 4, 3, 0);
    measure(p); measure(p);
    chk(p == 20, "R2 period 20 clocks", p, 20);
    chk(gap == 8, "R3 sample to bit gap", gap, 8);
    chk(cfg_err == 0, "R4 valid cfg", cfg_err, 0);

    setup(1, 6, 2, 1);
    measure(p); measure(p);
    chk(p == 44, "R2 period B", p, 44);
    chk(gap == 12, "R3 gap B", gap, 12);
    edge_test(1, 4, 48, "R5 late k1");
    edge_test(5, 4, 52, "R5 late k5 clipped");
    edge_test(8, 4, 36, "R6 early e2");
    edge_test(9, 4, 40, "R6 early e1");
    edge_test(10, 4, 44, "R6 early e0");
    edge_test(0, 4, 44, "R7 edge in sync ignored");
    wait_bs;
    pulse(8);
    pulse(6);
    measure(p);
    chk(p == 52, "R7 second edge ignored", p, 52);
    hsync_en = 1;
    edge_test(3, 4, 58, "R8 hard sync restart");
    hsync_en = 0;
    measure(p);
    chk(p == 44, "R8 nominal after hard sync", p, 44);

    setup(2, 15, 7, 3);
    measure(p); measure(p);
    chk(p == 150, "R2 period C", p, 150);
    chk(gap == 48, "R3 gap C", gap, 48);
    edge_test(10, 6, 174, "R5 late clip sjw4");
    edge_test(17, 6, 126, "R6 early clip sjw4");

    setup(0, 3, 3, 0);
    #4 chk(cfg_err == 1, "R4 tseg1 equal tseg2", cfg_err, 1);
    setup(0, 4, 0, 0);
    #4 chk(cfg_err == 1, "R4 tseg2 zero", cfg_err, 1);
    setup(0, 2, 1, 0);
    #4 chk(cfg_err == 0, "R4 minimal valid", cfg_err, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule